// File: doc/BRIEF.md
# Two-Cell Pack Protection Controller

This block is the digital decision core of a protector for a pack made of two lithium cells in series. Analog comparators outside the block turn cell voltages and sense-resistor drops into flags. From those flags the block decides, on every clock, whether the charge path and the discharge path may be closed. It also reports whether it is in its low-power sleep state. Each output is a plain logic level. Drivers and output stages for the power switches sit outside the block.

Cell-voltage flags (over the high limit, under the re-enable limit, under the low limit, input open) are captured only on a periodic sample tick. The sample tick is derived from a slow enable tick. The overcurrent and charger-present flags are observed on every clock. Each fault must persist for a delay before it acts. The delay is set in slow ticks by a parameter, so a short build can use small values. An undervoltage trip puts the block to sleep, and only a charger can wake it. A high-voltage trip inhibits charging until every cell is under the lower re-enable limit. A pack-disable input opens both paths at once.

Top module: `pack_guard`

## Requirements
- R1: After reset `sleep_o` is 1, `dsg_en` is 0 and `chg_en` is 1.
- R2: While asleep, a high `chg_det` sampled on a clock edge ends sleep. Two clock edges after that sample, `sleep_o` is 0 and `dsg_en` is 1.
- R3: When any bit of `cell_ov` or `cell_open` stays high, `chg_en` falls. It stays 1 for at least OV_DLY edges and is 0 no later than OV_DLY + SAMPLE_DIV + 3 edges, with SLOW_DIV = 1.
- R4: After a high-voltage trip, `chg_en` stays 0 while any bit of `cell_below_ce` is 0. It returns to 1 within SAMPLE_DIV + 4 edges once every bit of `cell_below_ce` is 1 and no high-voltage or open flag is set.
- R5: When any bit of `cell_uv` stays high, the block enters sleep. Both outputs follow together: `sleep_o` becomes 1 and `dsg_en` becomes 0, in the same window as R3 but with UV_DLY. The trip needs a bit of `cell_uv` to still be high when the delay expires.
- R6: With `oc_det` held high, `dsg_en` falls on exactly edge OC_FILT + OC_DLY + 1 after the assertion. `dsg_en` returns to 1 one edge after `oc_det` goes low.
- R7: A fault flag that drops before its delay completes leaves both outputs unchanged, and the next occurrence starts a fresh delay.
- R8: While `pack_off` is high, both `chg_en` and `dsg_en` are 0 from the next edge on. The overcurrent delay does not run during that time. It starts counting only after `pack_off` returns low.
- R9: While asleep, the cell-voltage flags are not sampled, so a sustained high-voltage flag leaves `chg_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_ov | input | N_CELLS | Per cell: above the high-voltage limit |
| cell_below_ce | input | N_CELLS | Per cell: below the charge re-enable limit |
| cell_uv | input | N_CELLS | Per cell: below the low-voltage limit |
| cell_open | input | N_CELLS | Per cell: sense input open; treated as high voltage |
| oc_det | input | 1 | Discharge overcurrent comparator flag |
| chg_det | input | 1 | Charger-present comparator flag |
| pack_off | input | 1 | High opens both paths |
| chg_en | output | 1 | 1 = charge path may close |
| dsg_en | output | 1 | 1 = discharge path may close |
| sleep_o | output | 1 | 1 = block is in low-power sleep |

## Verification
On every cycle the checker confirms four properties:
- pack-disable forces both enables low on the next edge;
- sleep never coexists with discharge enabled;
- a charger always ends sleep within two edges;
- discharge-enable falls only after a disable, an overcurrent flag, or entry into sleep, and charge-enable never rises right after a disable cycle.

Other behaviour can only be shown by the bench scenarios. These scenarios cover:
- the exact overcurrent timing, including pulses just short of and just past the trip length;
- the held overcurrent timer under pack-disable;
- the windows for the sampled voltage faults and the re-enable hysteresis;
- the refusal to sample while asleep.

// File: rtl/pg_pkg.sv
package pg_pkg;
  // width of a counter that must hold values 0..max_val
  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/pg_tick_gen.sv
module pg_tick_gen #(
  parameter int unsigned SLOW_DIV   = 1000,
  parameter int unsigned SAMPLE_DIV = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic slow_en,
  output logic samp_tick
);
  localparam int unsigned SW = pg_pkg::cnt_w(SAMPLE_DIV);

  generate
    if (SLOW_DIV <= 1) begin : g_fast
      assign slow_en = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = pg_pkg::cnt_w(SLOW_DIV);
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk) begin
        if (rst || dcnt == DW'(SLOW_DIV - 1)) dcnt <= '0;
        else                                  dcnt <= dcnt + 1'b1;
      end
      assign slow_en = (dcnt == DW'(SLOW_DIV - 1));
    end
  endgenerate

  logic [SW-1:0] scnt;
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      scnt      <= '0;
      samp_tick <= 1'b0;
    end else begin
      samp_tick <= 1'b0;
      if (slow_en) begin
        if (scnt == SW'(SAMPLE_DIV - 1)) begin
          scnt      <= '0;
          samp_tick <= 1'b1;
        end else begin
          scnt <= scnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pg_fault_timer.sv
module pg_fault_timer #(
  parameter int unsigned DLY = 950
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic cond,
  output logic done
);
  localparam int unsigned CW = pg_pkg::cnt_w(DLY);
  logic [CW-1:0] cnt;

  // reloads whenever the condition is absent; counts down only while present
  always_ff @(posedge clk) begin
    if (rst || !cond)              cnt <= CW'(DLY);
    else if (step && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = cond && (cnt == '0);
endmodule

// File: rtl/pack_guard.sv
module pack_guard #(
  parameter int unsigned N_CELLS    = 2,
  parameter int unsigned SLOW_DIV   = 1000,
  parameter int unsigned SAMPLE_DIV = 60,
  parameter int unsigned OV_DLY     = 950,
  parameter int unsigned UV_DLY     = 950,
  parameter int unsigned OC_DLY     = 12,
  parameter int unsigned OC_FILT    = 1500
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CELLS-1:0] cell_ov,
  input  logic [N_CELLS-1:0] cell_below_ce,
  input  logic [N_CELLS-1:0] cell_uv,
  input  logic [N_CELLS-1:0] cell_open,
  input  logic               oc_det,
  input  logic               chg_det,
  input  logic               pack_off,
  output logic               chg_en,
  output logic               dsg_en,
  output logic               sleep_o
);
  localparam int unsigned FW = pg_pkg::cnt_w(OC_FILT);

  logic slow_en, samp_tick, sleep_q;
  logic s_any_ov, s_all_ce, s_any_uv;
  logic ov_exp, uv_exp, oc_exp, uv_trip;
  logic ov_latch;
  logic [FW-1:0] fcnt;
  logic oc_f;

  pg_tick_gen #(.SLOW_DIV(SLOW_DIV), .SAMPLE_DIV(SAMPLE_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(!sleep_q),
    .slow_en(slow_en), .samp_tick(samp_tick)
  );

  // sampled cell view, cleared while asleep so a wake starts clean
  always_ff @(posedge clk) begin
    if (rst || sleep_q) begin
      s_any_ov <= 1'b0;
      s_all_ce <= 1'b0;
      s_any_uv <= 1'b0;
    end else if (samp_tick) begin
      s_any_ov <= |(cell_ov | cell_open);
      s_all_ce <= &cell_below_ce;
      s_any_uv <= |cell_uv;
    end
  end

  pg_fault_timer #(.DLY(OV_DLY)) u_ov_tmr (
    .clk(clk), .rst(rst), .step(slow_en), .cond(s_any_ov), .done(ov_exp)
  );

  pg_fault_timer #(.DLY(UV_DLY)) u_uv_tmr (
    .clk(clk), .rst(rst), .step(slow_en), .cond(s_any_uv), .done(uv_exp)
  );

  // re-check the live flags at expiry
  assign uv_trip = uv_exp && (|cell_uv);

  // continuous short filter on the overcurrent flag, in clock cycles
  always_ff @(posedge clk) begin
    if (rst || !oc_det)          fcnt <= '0;
    else if (fcnt != FW'(OC_FILT)) fcnt <= fcnt + 1'b1;
  end
  assign oc_f = oc_det && (fcnt == FW'(OC_FILT));

  pg_fault_timer #(.DLY(OC_DLY)) u_oc_tmr (
    .clk(clk), .rst(rst), .step(slow_en), .cond(oc_f && !pack_off), .done(oc_exp)
  );

  always_ff @(posedge clk) begin
    if (rst)                          ov_latch <= 1'b0;
    else if (ov_exp)                  ov_latch <= 1'b1;
    else if (s_all_ce && !s_any_ov)   ov_latch <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                     sleep_q <= 1'b1;
    else if (sleep_q && chg_det) sleep_q <= 1'b0;
    else if (uv_trip)            sleep_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_en  <= 1'b1;
      dsg_en  <= 1'b0;
      sleep_o <= 1'b1;
    end else begin
      chg_en  <= !pack_off && !ov_latch;
      dsg_en  <= !pack_off && !sleep_q && !oc_exp;
      sleep_o <= sleep_q;
    end
  end
endmodule

// File: rtl/pack_guard_chk.sv
module pack_guard_chk #(
  parameter int unsigned N_CELLS = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [N_CELLS-1:0] cell_ov,
  input logic               oc_det,
  input logic               chg_det,
  input logic               pack_off,
  input logic               chg_en,
  input logic               dsg_en,
  input logic               sleep_o
);
  p_pack_off_r8: assert property (@(posedge clk) disable iff (rst)
    pack_off |=> (!chg_en && !dsg_en));

  p_sleep_no_dsg_r5: assert property (@(posedge clk) disable iff (rst)
    sleep_o |-> !dsg_en);

  p_wake_r2: assert property (@(posedge clk) disable iff (rst)
    (sleep_o && chg_det) |=> ##1 !sleep_o);

  p_dsg_fall_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(dsg_en) |-> ($past(pack_off) || sleep_o || $past(oc_det)));

  p_chg_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(chg_en) |-> !$past(pack_off));
endmodule

bind pack_guard pack_guard_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk(clk), .rst(rst), .cell_ov(cell_ov), .oc_det(oc_det), .chg_det(chg_det),
  .pack_off(pack_off), .chg_en(chg_en), .dsg_en(dsg_en), .sleep_o(sleep_o)
);

// File: tb/pack_guard_bench.sv
`timescale 1ns/1ps
module pack_guard_bench;
  localparam int unsigned NC = 2, SD = 1, SMP = 4, OVD = 20, UVD = 20, OCD = 6, OCF = 3;
  localparam int unsigned OC_TRIP = OCF + OCD + 1;   // edge on which dsg_en falls

  logic clk = 1'b0, rst = 1'b1;
  logic [NC-1:0] cell_ov = '0, cell_below_ce = '0, cell_uv = '0, cell_open = '0;
  logic oc_det = 1'b0, chg_det = 1'b0, pack_off = 1'b0;
  logic chg_en, dsg_en, sleep_o;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  pack_guard #(.N_CELLS(NC), .SLOW_DIV(SD), .SAMPLE_DIV(SMP), .OV_DLY(OVD),
               .UV_DLY(UVD), .OC_DLY(OCD), .OC_FILT(OCF)) u_pack_guard (
    .clk(clk), .rst(rst), .cell_ov(cell_ov), .cell_below_ce(cell_below_ce),
    .cell_uv(cell_uv), .cell_open(cell_open), .oc_det(oc_det), .chg_det(chg_det),
    .pack_off(pack_off), .chg_en(chg_en), .dsg_en(dsg_en), .sleep_o(sleep_o)
  );

  function automatic logic oc_expect_dsg(input int unsigned held);
    return (held >= OC_TRIP) ? 1'b0 : 1'b1;
  endfunction

  task automatic step(input int unsigned n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      report();
    end
  end

  initial begin
    void'($urandom(32'd2058));
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sleep", sleep_o, 1'b1);
    chk("R1 dsg", dsg_en, 1'b0);
    chk("R1 chg", chg_en, 1'b1);

    // R9: no sampling while asleep
    cell_ov[0] = 1'b1; step(60);
    chk("R9 chg held", chg_en, 1'b1);
    chk("R9 still asleep", sleep_o, 1'b1);
    cell_ov[0] = 1'b0;

    // R2: charger wakes
    chg_det = 1'b1; step(1); chg_det = 1'b0; step(1);
    chk("R2 sleep", sleep_o, 1'b0);
    chk("R2 dsg", dsg_en, 1'b1);
    step(10);

    // R6 directed
    oc_det = 1'b1; step(OC_TRIP - 1);
    chk("R6 before trip", dsg_en, 1'b1);
    step(1);
    chk("R6 trip", dsg_en, 1'b0);
    oc_det = 1'b0; step(1);
    chk("R6 release", dsg_en, 1'b1);

    // R7 random overcurrent pulses
    for (int i = 0; i < 24; i++) begin
      int unsigned len;
      len = 1 + ($urandom % 14);
      oc_det = 1'b1; step(len);
      chk("R7 oc pulse", dsg_en, oc_expect_dsg(len));
      oc_det = 1'b0; step(2);
      chk("R7 oc recover", dsg_en, 1'b1);
    end

    // R8 pack disable holds the overcurrent timer
    pack_off = 1'b1; step(1);
    chk("R8 chg off", chg_en, 1'b0);
    chk("R8 dsg off", dsg_en, 1'b0);
    oc_det = 1'b1; step(30);
    chk("R8 held dsg", dsg_en, 1'b0);
    pack_off = 1'b0; step(OCD);
    chk("R8 timer restarted", dsg_en, 1'b1);
    step(1);
    chk("R8 timer expiry", dsg_en, 1'b0);
    oc_det = 1'b0; step(2);
    chk("R8 recover", dsg_en, 1'b1);

    // R3 / R4 high voltage and hysteresis
    cell_ov[1] = 1'b1; step(OVD);
    chk("R3 not yet", chg_en, 1'b1);
    step(SMP + 3);
    chk("R3 trip", chg_en, 1'b0);
    cell_ov[1] = 1'b0; cell_below_ce = 2'b01; step(40);
    chk("R4 hysteresis hold", chg_en, 1'b0);
    cell_below_ce = 2'b11; step(SMP + 4);
    chk("R4 release", chg_en, 1'b1);
    cell_below_ce = 2'b00;

    // R3 open cell input
    cell_open[0] = 1'b1; step(OVD + SMP + 3);
    chk("R3 open trip", chg_en, 1'b0);
    cell_open[0] = 1'b0; cell_below_ce = 2'b11; step(SMP + 4);
    chk("R4 open release", chg_en, 1'b1);
    cell_below_ce = 2'b00;

    // R7 short voltage faults
    cell_ov[0] = 1'b1; step(10); cell_ov[0] = 1'b0; step(40);
    chk("R7 short ov", chg_en, 1'b1);
    cell_uv[1] = 1'b1; step(10); cell_uv[1] = 1'b0; step(40);
    chk("R7 short uv sleep", sleep_o, 1'b0);
    chk("R7 short uv dsg", dsg_en, 1'b1);

    // R5 undervoltage into sleep
    cell_uv[0] = 1'b1; step(UVD);
    chk("R5 not yet", sleep_o, 1'b0);
    step(SMP + 4);
    chk("R5 sleep", sleep_o, 1'b1);
    chk("R5 dsg", dsg_en, 1'b0);
    cell_uv[0] = 1'b0;
    chg_det = 1'b1; step(2); chg_det = 1'b0;
    chk("R2 rewake", dsg_en, 1'b1);

    finished = 1'b1;
    report();
  end
endmodule